// File: doc/BRIEF.md
# SRAM-Style Asynchronous Memory Cycle Generator

This block sits between a synchronous request port and an external 16-bit asynchronous memory with an SRAM-like pin set. Each accepted request carries a direction, an address, a data word and a two-bit lane-enable mask. The block turns it into one asynchronous cycle on active-low chip select, output enable, write enable and two lane strobes. The data bus is split into an output word, an output enable and an input word, so it can be joined to a tri-state pad. A read returns its data through a one-cycle valid pulse.

Every phase of the cycle lasts a whole number of clocks. Each count is the nanosecond timing figure multiplied by the clock rate and rounded up. There are two write profiles. The normal profile applies to isolated writes and to short runs of writes. Once a run of back-to-back writes passes a programmed length, the slower profile takes over. Any read, and any clock spent idle, ends the run. A new request is accepted in the last cycle of the current one, so contiguous traffic has no gap.

Top module: `asram_cycle_gen`

## Requirements
- R1: While reset is active, and on its release, chip select, output enable, write enable and both lane strobes are high, the data bus is not driven, rd_valid is low and req_ready is high.
- R2: Mask bit 0 enables the lower lane (data bits 7:0, strobe mem_lb_n) and mask bit 1 enables the upper lane (bits 15:8, strobe mem_ub_n). A write changes only the enabled lanes. A lane strobe is never low while chip select is high.
- R3: A read holds chip select low for one lead clock with output enable high. It then holds output enable low for max(address access, output-enable access, read cycle minus one) clocks, 25 at the default settings. The bus is sampled in the last of those clocks. rd_valid is high for exactly one clock, the clock in which output enable has just returned high. rd_data carries zero in lanes that were not enabled.
- R4: The data bus is never driven while output enable is low, and output enable and write enable are never low together.
- R5: A normal write lasts 25 clocks at the defaults. It has a setup of max(1, address setup, chip-select/address/lane valid minus pulse) clocks, then a write-enable pulse of 18 clocks, then recovery for the rest of the write cycle (at least 1 clock). Address and data are held steady for the whole pulse, and the data bus stays driven until the recovery ends.
- R6: A request with mask 00 runs a full cycle with both lane strobes high. Neither output enable nor write enable falls, memory is left unchanged, and a read of this kind still pulses rd_valid with rd_data equal to zero.
- R7: In a run of back-to-back writes, writes 1 to 20 use the normal profile. Every later write uses the long profile: a 25-clock pulse and a 28-clock write cycle at the defaults.
- R8: A read, or a single idle clock, resets the run count, so the next write uses the normal profile.
- R9: While req_valid is held high, the next request is accepted in the last clock of the current cycle. A write is then 25 or 28 clocks long and a read 26 clocks, with no idle clock between them.
- R10: Write enable is low only while chip select is low and at least one lane strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken on this clock edge when valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | 16 | Write data |
| req_ben | input | 2 | Lane enables, bit 0 lower, bit 1 upper |
| rd_valid | output | 1 | One-clock read data strobe |
| rd_data | output | 16 | Captured read data, disabled lanes zero |
| mem_addr | output | AW | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lb_n | output | 1 | Lower lane strobe, active low |
| mem_ub_n | output | 1 | Upper lane strobe, active low |
| mem_dq_o | output | 16 | Data driven toward memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | 16 | Data returned from memory |

## Verification
All memory pins are registered. A pin change therefore becomes visible one clock edge after the acceptance edge or the phase boundary that causes it. The bench measures that change at the next falling edge. It does not predict absolute times. Instead it counts falling edges of write-enable and output-enable low time, and it counts clocks between acceptance edges. This gives the pulse widths and cycle lengths directly (18, 25, 25, 26, 28) for comparison with R3, R5, R7 and R9. rd_valid is due in the same clock in which output enable is first seen high after an access, and the bench checks it at exactly that falling edge.

// File: rtl/asram_pkg.sv
package asram_pkg;

  localparam int CNT_W = 16;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RLEAD,
    PH_RACC,
    PH_WSET,
    PH_WPUL,
    PH_WREC
  } phase_e;

  // Clock counts for the three write phases.
  typedef struct packed {
    cnt_t set_n;
    cnt_t pul_n;
    cnt_t rec_n;
  } wprof_t;

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // Nanoseconds to clocks, rounded up.
  function automatic int ns_to_clk(int ns, longint hz);
    longint prod;
    prod = longint'(ns) * hz;
    return int'((prod + 64'd999_999_999) / 64'd1_000_000_000);
  endfunction

  function automatic wprof_t mk_prof(int wc, int wp, int cw, int aw, int bw, int as_c);
    wprof_t r;
    int     s;
    int     p;
    s = imax(1, imax(as_c, imax(cw - wp, imax(aw - wp, bw - wp))));
    p = imax(1, wp);
    r.set_n = cnt_t'(s);
    r.pul_n = cnt_t'(p);
    r.rec_n = cnt_t'(imax(1, wc - s - p));
    return r;
  endfunction

endpackage

// File: rtl/asram_timing.sv
module asram_timing
  import asram_pkg::*;
#(
  parameter longint CLK_HZ    = 250_000_000,
  parameter int     NWC_NS    = 100,
  parameter int     NWP_NS    = 70,
  parameter int     NCW_NS    = 80,
  parameter int     NAW_NS    = 80,
  parameter int     NBW_NS    = 80,
  parameter int     AS_NS     = 0,
  parameter int     LWC_NS    = 110,
  parameter int     LWP_NS    = 100,
  parameter int     LCW_NS    = 100,
  parameter int     LAW_NS    = 100,
  parameter int     LBW_NS    = 100,
  parameter int     RC_NS     = 100,
  parameter int     AA_NS     = 100,
  parameter int     OE_NS     = 50,
  parameter int     BURST_LIM = 20
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wr_start,
  input  logic   burst_clr,
  output wprof_t prof,
  output cnt_t   rd_acc
);

  localparam int N_AS = ns_to_clk(AS_NS, CLK_HZ);
  localparam wprof_t PROF_N = mk_prof(ns_to_clk(NWC_NS, CLK_HZ), ns_to_clk(NWP_NS, CLK_HZ),
                                      ns_to_clk(NCW_NS, CLK_HZ), ns_to_clk(NAW_NS, CLK_HZ),
                                      ns_to_clk(NBW_NS, CLK_HZ), N_AS);
  localparam wprof_t PROF_L = mk_prof(ns_to_clk(LWC_NS, CLK_HZ), ns_to_clk(LWP_NS, CLK_HZ),
                                      ns_to_clk(LCW_NS, CLK_HZ), ns_to_clk(LAW_NS, CLK_HZ),
                                      ns_to_clk(LBW_NS, CLK_HZ), N_AS);
  localparam int RD_ACC_N = imax(1, imax(ns_to_clk(AA_NS, CLK_HZ),
                                 imax(ns_to_clk(OE_NS, CLK_HZ), ns_to_clk(RC_NS, CLK_HZ) - 1)));
  localparam int BC_W = $clog2(BURST_LIM + 1);

  logic [BC_W-1:0] run_q;
  logic [BC_W-1:0] run_d;
  logic            run_en;
  logic            at_lim;

  assign at_lim = (run_q >= BC_W'(BURST_LIM));
  assign run_en = burst_clr | wr_start;
  assign rd_acc = cnt_t'(RD_ACC_N);
  assign prof   = (at_lim && !burst_clr) ? PROF_L : PROF_N;

  always_comb begin
    run_d = run_q;
    if (burst_clr) begin
      run_d = wr_start ? BC_W'(1) : '0;
    end else if (wr_start && !at_lim) begin
      run_d = run_q + BC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (run_en) begin
      run_q <= run_d;
    end
  end

endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_valid,
  input  logic   req_we,
  input  wprof_t prof,
  input  cnt_t   rd_acc,
  output logic   req_ready,
  output logic   accept,
  output logic   wr_start,
  output logic   burst_clr,
  output logic   rd_cap,
  output phase_e ph_d
);

  phase_e ph_q;
  cnt_t   cnt_q;
  cnt_t   cnt_d;
  wprof_t wp_q;
  wprof_t wp_d;
  logic   last;
  logic   free;
  logic   step_en;

  assign last      = (cnt_q == '0) && ((ph_q == PH_RACC) || (ph_q == PH_WREC));
  assign free      = (ph_q == PH_IDLE) || last;
  assign req_ready = free;
  assign accept    = req_valid && free;
  assign wr_start  = accept && req_we;
  assign burst_clr = (ph_q == PH_IDLE) || (accept && !req_we);
  assign rd_cap    = last && (ph_q == PH_RACC);
  assign step_en   = (ph_q != PH_IDLE) || accept;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    wp_d  = wp_q;
    if (free) begin
      if (accept && req_we) begin
        ph_d  = PH_WSET;
        cnt_d = prof.set_n - cnt_t'(1);
        wp_d  = prof;
      end else if (accept) begin
        ph_d  = PH_RLEAD;
        cnt_d = '0;
      end else begin
        ph_d  = PH_IDLE;
        cnt_d = '0;
      end
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - cnt_t'(1);
    end else begin
      unique case (ph_q)
        PH_RLEAD: begin
          ph_d  = PH_RACC;
          cnt_d = rd_acc - cnt_t'(1);
        end
        PH_WSET: begin
          ph_d  = PH_WPUL;
          cnt_d = wp_q.pul_n - cnt_t'(1);
        end
        PH_WPUL: begin
          ph_d  = PH_WREC;
          cnt_d = wp_q.rec_n - cnt_t'(1);
        end
        default: begin
          ph_d  = PH_IDLE;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      wp_q  <= '0;
    end else if (step_en) begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      wp_q  <= wp_d;
    end
  end

endmodule

// File: rtl/asram_pins.sv
module asram_pins
  import asram_pkg::*;
#(
  parameter int AW     = 21,
  parameter int LANE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                accept,
  input  logic [AW-1:0]       req_addr,
  input  logic [2*LANE_W-1:0] req_wdata,
  input  logic [1:0]          req_ben,
  input  phase_e              ph_d,
  input  logic                rd_cap,
  input  logic [2*LANE_W-1:0] mem_dq_i,
  output logic [AW-1:0]       mem_addr,
  output logic                mem_cs_n,
  output logic                mem_oe_n,
  output logic                mem_we_n,
  output logic                mem_lb_n,
  output logic                mem_ub_n,
  output logic [2*LANE_W-1:0] mem_dq_o,
  output logic                mem_dq_oe,
  output logic                rd_valid,
  output logic [2*LANE_W-1:0] rd_data
);

  localparam int DW = 2 * LANE_W;

  logic [AW-1:0] addr_q;
  logic [DW-1:0] wd_q;
  logic [1:0]    ben_q;
  logic [AW-1:0] addr_d;
  logic [DW-1:0] wd_d;
  logic [1:0]    ben_d;
  logic          act;
  logic          wr_ph;
  logic          any_lane;
  logic [1:0]    lane_n_d;
  logic [1:0]    lane_n_q;
  logic [DW-1:0] cap_d;

  assign addr_d   = accept ? req_addr  : addr_q;
  assign wd_d     = accept ? req_wdata : wd_q;
  assign ben_d    = accept ? req_ben   : ben_q;
  assign act      = (ph_d != PH_IDLE);
  assign wr_ph    = (ph_d == PH_WSET) || (ph_d == PH_WPUL) || (ph_d == PH_WREC);
  assign any_lane = |ben_d;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    assign lane_n_d[g]              = !(act && ben_d[g]);
    assign cap_d[g*LANE_W +: LANE_W] = ben_q[g] ? mem_dq_i[g*LANE_W +: LANE_W] : '0;
  end

  assign mem_lb_n = lane_n_q[0];
  assign mem_ub_n = lane_n_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      wd_q   <= '0;
      ben_q  <= '0;
    end else if (accept) begin
      addr_q <= req_addr;
      wd_q   <= req_wdata;
      ben_q  <= req_ben;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_cs_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      lane_n_q  <= 2'b11;
      mem_dq_oe <= 1'b0;
      mem_addr  <= '0;
      mem_dq_o  <= '0;
    end else begin
      mem_cs_n  <= !act;
      mem_oe_n  <= !((ph_d == PH_RACC) && any_lane);
      mem_we_n  <= !((ph_d == PH_WPUL) && any_lane);
      lane_n_q  <= lane_n_d;
      mem_dq_oe <= wr_ph && any_lane;
      mem_addr  <= addr_d;
      mem_dq_o  <= wd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_cap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (rd_cap) begin
      rd_data <= cap_d;
    end
  end

endmodule

// File: rtl/asram_cycle_gen.sv
module asram_cycle_gen
  import asram_pkg::*;
#(
  parameter longint CLK_HZ    = 250_000_000,
  parameter int     AW        = 21,
  parameter int     LANE_W    = 8,
  parameter int     NWC_NS    = 100,
  parameter int     NWP_NS    = 70,
  parameter int     NCW_NS    = 80,
  parameter int     NAW_NS    = 80,
  parameter int     NBW_NS    = 80,
  parameter int     AS_NS     = 0,
  parameter int     LWC_NS    = 110,
  parameter int     LWP_NS    = 100,
  parameter int     LCW_NS    = 100,
  parameter int     LAW_NS    = 100,
  parameter int     LBW_NS    = 100,
  parameter int     RC_NS     = 100,
  parameter int     AA_NS     = 100,
  parameter int     OE_NS     = 50,
  parameter int     BURST_LIM = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_we,
  input  logic [AW-1:0]       req_addr,
  input  logic [2*LANE_W-1:0] req_wdata,
  input  logic [1:0]          req_ben,
  output logic                rd_valid,
  output logic [2*LANE_W-1:0] rd_data,
  output logic [AW-1:0]       mem_addr,
  output logic                mem_cs_n,
  output logic                mem_oe_n,
  output logic                mem_we_n,
  output logic                mem_lb_n,
  output logic                mem_ub_n,
  output logic [2*LANE_W-1:0] mem_dq_o,
  output logic                mem_dq_oe,
  input  logic [2*LANE_W-1:0] mem_dq_i
);

  wprof_t prof;
  cnt_t   rd_acc;
  logic   accept;
  logic   wr_start;
  logic   burst_clr;
  logic   rd_cap;
  phase_e ph_d;

  asram_timing #(
    .CLK_HZ(CLK_HZ), .NWC_NS(NWC_NS), .NWP_NS(NWP_NS), .NCW_NS(NCW_NS),
    .NAW_NS(NAW_NS), .NBW_NS(NBW_NS), .AS_NS(AS_NS), .LWC_NS(LWC_NS),
    .LWP_NS(LWP_NS), .LCW_NS(LCW_NS), .LAW_NS(LAW_NS), .LBW_NS(LBW_NS),
    .RC_NS(RC_NS), .AA_NS(AA_NS), .OE_NS(OE_NS), .BURST_LIM(BURST_LIM)
  ) u_timing (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_start (wr_start),
    .burst_clr(burst_clr),
    .prof     (prof),
    .rd_acc   (rd_acc)
  );

  asram_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_we   (req_we),
    .prof     (prof),
    .rd_acc   (rd_acc),
    .req_ready(req_ready),
    .accept   (accept),
    .wr_start (wr_start),
    .burst_clr(burst_clr),
    .rd_cap   (rd_cap),
    .ph_d     (ph_d)
  );

  asram_pins #(.AW(AW), .LANE_W(LANE_W)) u_pins (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .req_ben  (req_ben),
    .ph_d     (ph_d),
    .rd_cap   (rd_cap),
    .mem_dq_i (mem_dq_i),
    .mem_addr (mem_addr),
    .mem_cs_n (mem_cs_n),
    .mem_oe_n (mem_oe_n),
    .mem_we_n (mem_we_n),
    .mem_lb_n (mem_lb_n),
    .mem_ub_n (mem_ub_n),
    .mem_dq_o (mem_dq_o),
    .mem_dq_oe(mem_dq_oe),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

endmodule

// File: rtl/asram_cycle_gen_chk.sv
module asram_cycle_gen_chk #(
  parameter int AW     = 21,
  parameter int LANE_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_ready,
  input logic                rd_valid,
  input logic [AW-1:0]       mem_addr,
  input logic                mem_cs_n,
  input logic                mem_oe_n,
  input logic                mem_we_n,
  input logic                mem_lb_n,
  input logic                mem_ub_n,
  input logic [2*LANE_W-1:0] mem_dq_o,
  input logic                mem_dq_oe
);

  p_reset_quiet_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (mem_cs_n && mem_oe_n && mem_we_n && mem_lb_n && mem_ub_n &&
                      !mem_dq_oe && !rd_valid && req_ready));

  p_lane_needs_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_lb_n || !mem_ub_n) |-> !mem_cs_n);

  p_rdv_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  p_no_fight_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe);

  p_oe_we_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  p_pulse_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_o)));

  p_recovery_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (mem_dq_oe && !mem_cs_n));

  p_we_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_cs_n && !(mem_lb_n && mem_ub_n)));

endmodule

bind asram_cycle_gen asram_cycle_gen_chk #(.AW(AW), .LANE_W(LANE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_ready(req_ready),
  .rd_valid (rd_valid),
  .mem_addr (mem_addr),
  .mem_cs_n (mem_cs_n),
  .mem_oe_n (mem_oe_n),
  .mem_we_n (mem_we_n),
  .mem_lb_n (mem_lb_n),
  .mem_ub_n (mem_ub_n),
  .mem_dq_o (mem_dq_o),
  .mem_dq_oe(mem_dq_oe)
);

// File: tb/sim_asram_cycle_gen.sv
module sim_asram_cycle_gen;

  localparam int AW = 21;
  // Expected clock counts at 250 MHz, derived from the ns figures.
  localparam int E_WPN = 18;
  localparam int E_WCN = 25;
  localparam int E_WPL = 25;
  localparam int E_WCL = 28;
  localparam int E_OE  = 25;
  localparam int E_RD  = 26;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0]   req_wdata = '0;
  logic [1:0]    req_ben = '0;
  logic          rd_valid;
  logic [15:0]   rd_data;
  logic [AW-1:0] mem_addr;
  logic          mem_cs_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe;
  logic [15:0]   mem_dq_o;
  logic [15:0]   mem_dq_i;

  asram_cycle_gen #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata), .req_ben(req_ben),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  always #2 clk = ~clk;

  int     checks = 0;
  int     errors = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Memory model: lanes not enabled float to a junk value.
  logic [15:0] mem [0:255];
  logic [7:0]  ma;
  assign ma = mem_addr[7:0];
  assign mem_dq_i = (!mem_cs_n && !mem_oe_n) ?
                    {(!mem_ub_n ? mem[ma][15:8] : 8'hEE), (!mem_lb_n ? mem[ma][7:0] : 8'hEE)} :
                    16'hEEEE;
  always @(posedge mem_we_n) begin
    if (!mem_cs_n && mem_dq_oe) begin
      if (!mem_lb_n) mem[ma][7:0]  = mem_dq_o[7:0];
      if (!mem_ub_n) mem[ma][15:8] = mem_dq_o[15:8];
    end
  end

  // Monitors, sampled on the falling edge.
  int          fight = 0, wegate = 0, we_run = 0, oe_run = 0, we_idx = 0;
  int          we_w [0:63];
  int          last_oe_w = 0, rd_cnt = 0, oe_any = 0, we_any = 0;
  logic        rdv_at_rise = 1'b0;
  logic [15:0] last_rd = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_dq_oe && !mem_oe_n) fight++;
      if (!mem_we_n && (mem_cs_n || (mem_lb_n && mem_ub_n))) wegate++;
      if (!mem_we_n) begin
        we_run++; we_any++;
      end else if (we_run > 0) begin
        if (we_idx < 64) we_w[we_idx] = we_run;
        we_idx++; we_run = 0;
      end
      if (!mem_oe_n) begin
        oe_run++; oe_any++;
      end else if (oe_run > 0) begin
        last_oe_w = oe_run; oe_run = 0; rdv_at_rise = rd_valid;
      end
      if (rd_valid) begin
        rd_cnt++; last_rd = rd_data;
      end
    end
  end

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Operation queue driven with req_valid held high.
  logic        op_we  [0:63];
  logic [15:0] op_dat [0:63];
  logic [7:0]  op_adr [0:63];
  logic [1:0]  op_ben [0:63];
  longint      stamp  [0:63];

  task automatic run_ops(int n);
    for (int i = 0; i < n; ) begin
      @(negedge clk);
      req_valid = 1'b1;
      req_we    = op_we[i];
      req_addr  = AW'(op_adr[i]);
      req_wdata = op_dat[i];
      req_ben   = op_ben[i];
      if (req_ready) begin
        stamp[i] = cyc;
        i++;
      end
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (mem_cs_n && req_ready) break;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic one_op(logic we, logic [7:0] a, logic [15:0] d, logic [1:0] b);
    op_we[0] = we; op_adr[0] = a; op_dat[0] = d; op_ben[0] = b;
    run_ops(1);
    wait_idle();
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    chk("R1", "strobes high in reset", {mem_cs_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n}, 5'h1F);
    chk("R1", "bus idle in reset", {mem_dq_oe, rd_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "ready after release", req_ready, 1);
    chk("R1", "strobes high after release", {mem_cs_n, mem_oe_n, mem_we_n}, 3'h7);
  endtask

  task automatic t_word();
    int w0, r0;
    w0 = we_idx;
    one_op(1'b1, 8'd5, 16'hC3A5, 2'b11);
    chk("R2", "word write stored", mem[5], 16'hC3A5);
    chk("R5", "normal pulse width", we_w[w0], E_WPN);
    r0 = rd_cnt;
    one_op(1'b0, 8'd5, 16'h0, 2'b11);
    chk("R3", "word read data", last_rd, 16'hC3A5);
    chk("R3", "output enable width", last_oe_w, E_OE);
    chk("R3", "rd_valid with oe rise", rdv_at_rise, 1);
    chk("R3", "rd_valid one clock", rd_cnt - r0, 1);
  endtask

  task automatic t_bytes();
    one_op(1'b1, 8'd7, 16'hA1B2, 2'b11);
    one_op(1'b1, 8'd7, 16'hFF33, 2'b01);
    chk("R2", "lower lane only", mem[7], 16'hA133);
    one_op(1'b1, 8'd7, 16'h44FF, 2'b10);
    chk("R2", "upper lane only", mem[7], 16'h4433);
    one_op(1'b0, 8'd7, 16'h0, 2'b01);
    chk("R3", "lower read, upper zero", last_rd, 16'h0033);
    one_op(1'b0, 8'd7, 16'h0, 2'b10);
    chk("R3", "upper read, lower zero", last_rd, 16'h4400);
  endtask

  task automatic t_mask0();
    int wa, oa, r0;
    wa = we_any; oa = oe_any; r0 = rd_cnt;
    one_op(1'b1, 8'd7, 16'h1234, 2'b00);
    chk("R6", "mask 00 write leaves memory", mem[7], 16'h4433);
    chk("R6", "mask 00 write no we", we_any - wa, 0);
    one_op(1'b0, 8'd7, 16'h0, 2'b00);
    chk("R6", "mask 00 read valid", rd_cnt - r0, 1);
    chk("R6", "mask 00 read data", last_rd, 0);
    chk("R6", "mask 00 read no oe", oe_any - oa, 0);
  endtask

  task automatic t_burst_read_clear();
    int w0;
    w0 = we_idx;
    for (int k = 0; k < 21; k++) begin
      op_we[k] = 1'b1; op_adr[k] = 8'(32 + k); op_dat[k] = 16'(16'h1000 + k); op_ben[k] = 2'b11;
    end
    op_we[21] = 1'b0; op_adr[21] = 8'd35; op_dat[21] = '0; op_ben[21] = 2'b11;
    op_we[22] = 1'b1; op_adr[22] = 8'd60; op_dat[22] = 16'hBEEF; op_ben[22] = 2'b11;
    run_ops(23);
    wait_idle();
    for (int k = 0; k < 20; k++) begin
      chk("R7", $sformatf("write %0d pulse", k + 1), we_w[w0 + k], E_WPN);
      chk("R9", $sformatf("write %0d length", k + 1), stamp[k+1] - stamp[k], E_WCN);
    end
    chk("R7", "write 21 long pulse", we_w[w0 + 20], E_WPL);
    chk("R7", "write 21 long cycle", stamp[21] - stamp[20], E_WCL);
    chk("R9", "read length in stream", stamp[22] - stamp[21], E_RD);
    chk("R3", "read in stream data", last_rd, 16'h1003);
    chk("R8", "write after read normal", we_w[w0 + 21], E_WPN);
    chk("R2", "burst data stored", mem[52], 16'h1014);
  endtask

  task automatic t_idle_clear();
    int w0;
    w0 = we_idx;
    for (int k = 0; k < 21; k++) begin
      op_we[k] = 1'b1; op_adr[k] = 8'(64 + k); op_dat[k] = 16'(16'h2000 + k); op_ben[k] = 2'b11;
    end
    run_ops(21);
    wait_idle();
    chk("R7", "second burst write 21 long", we_w[w0 + 20], E_WPL);
    one_op(1'b1, 8'd90, 16'h7777, 2'b11);
    chk("R8", "write after idle normal", we_w[w0 + 21], E_WPN);
    chk("R2", "write after idle stored", mem[90], 16'h7777);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * 16'h0101) ^ 16'h5A5A;
    t_reset();
    t_word();
    t_bytes();
    t_mask0();
    t_burst_read_clear();
    t_idle_clear();
    chk("R4", "bus driven while oe low", fight, 0);
    chk("R10", "we low without cs or lane", wegate, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected completion earlier", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule